// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and the next memory level. Each processor store is captured as an address/data pair in a small ordered buffer. The processor can then continue without waiting for the slow memory write. The buffer sends its entries to memory one at a time, oldest first. It offers the current oldest entry on a request/acknowledge port and retires that entry on each acknowledge. The writer is held off only when a store arrives and every slot is already occupied. If memory acknowledges in that same cycle, a slot frees and the store is taken.

When the cache misses on a read, it presents the read address to the buffer together with a check strobe. The buffer compares the address against every occupied slot within the same cycle. It reports a hit when any slot matches. When several buffered stores target the same address, it returns the data of the most recently accepted one, so a read never sees stale memory contents. Reset empties the buffer by clearing every slot's occupancy bit.

Top module: `wt_store_buffer`

## Requirements
- R1: While the buffer holds fewer than DEPTH entries, a store (`st_valid`=1) is taken in that cycle, `st_stall` stays 0, and the entry count rises by one unless an entry also drains.
- R2: When the buffer holds DEPTH entries and `mem_ack` is 0, a presented store drives `st_stall`=1, is not stored, and the buffered contents do not change.
- R3: When the buffer holds DEPTH entries, `mem_ack` is 1 and a store is presented in the same cycle, the oldest entry retires and the new store is taken (`st_stall`=0), so no data is lost and the buffer stays full.
- R4: `mem_req` is 1 exactly when the buffer is non-empty. `mem_addr`/`mem_data` carry the oldest entry and do not change while `mem_req`=1 and `mem_ack`=0.
- R5: Entries reach the memory port in the order they were accepted, and exactly one entry retires per cycle in which `mem_req` and `mem_ack` are both 1.
- R6: With `rd_check`=1, `rd_hit` is 1 in the same cycle if any buffered entry's address equals `rd_addr`. `rd_data` then equals the data of the youngest matching entry.
- R7: `rd_hit` is 0 when `rd_check` is 0 or when no buffered entry matches `rd_addr`.
- R8: `empty` is 1 exactly when no entry is held, and `full` is 1 exactly when DEPTH entries are held.
- R9: After reset the buffer is empty: `empty`=1, `full`=0, `mem_req`=0, `rd_hit`=0.
- R10: `mem_ack` asserted while `mem_req` is 0 has no effect: the buffer stays empty and no entry is later presented for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store presented by the cache |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_stall | output | 1 | Store refused this cycle; writer must hold it |
| mem_req | output | 1 | Oldest entry offered to memory |
| mem_addr | output | AW | Address of oldest entry |
| mem_data | output | DW | Data of oldest entry |
| mem_ack | input | 1 | Memory takes the offered entry |
| rd_check | input | 1 | Read-miss lookup strobe |
| rd_addr | input | AW | Read-miss address to search |
| rd_hit | output | 1 | A buffered entry matches |
| rd_data | output | DW | Data of youngest matching entry |
| empty | output | 1 | No entries held |
| full | output | 1 | All DEPTH entries held |

## Verification
The bench builds the block with DEPTH=4, a narrow 8-bit address and 16-bit data. With only four slots, full, stall and the full-plus-drain case come up within a handful of cycles. The narrow address is combined with a few-value address pool, so several live entries often share an address, and the youngest-match selection is exercised under wrapped pointers. A random phase with stalling memory then mixes all of these against the reference queue model on every cycle.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int DEF_DEPTH = 4;
  localparam int DEF_AW    = 32;
  localparam int DEF_DW    = 32;

  // Advance a slot index with wrap at the buffer depth.
  function automatic int slot_next(input int idx, input int depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Physical slot at a given age offset from the oldest slot.
  function automatic int slot_at(input int head, input int offs, input int depth);
    int s;
    s = head + offs;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/wsb_ctrl.sv
module wsb_ctrl #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          mem_ack,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          st_stall
);
  import wsb_pkg::*;

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    empty    = (cnt_q == '0);
    full     = (cnt_q == CW'(DEPTH));
    pop      = !empty && mem_ack;
    push     = st_valid && (!full || pop);
    st_stall = st_valid && !push;

    wp_d  = push ? PW'(slot_next(int'(wp_q), DEPTH)) : wp_q;
    rp_d  = pop  ? PW'(slot_next(int'(rp_q), DEPTH)) : rp_q;
    cnt_en = push ^ pop;
    cnt_d  = cnt_q;
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)   wp_q  <= wp_d;
      if (pop)    rp_q  <= rp_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign wr_ptr = wp_q;
  assign rd_ptr = rp_q;
  assign count  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && !mem_ack |=> $stable(count)) else $error("overflow"); // R2
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    full && mem_ack && st_valid |=> full) else $error("swap lost"); // R3
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    empty && mem_ack && !st_valid |=> empty) else $error("stray ack"); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)) else $error("flags"); // R8
endmodule

// File: rtl/wsb_store.sv
module wsb_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [PW-1:0]            wr_ptr,
  input  logic [PW-1:0]            rd_ptr,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  output logic [DEPTH-1:0]         slot_vld,
  output logic [DEPTH-1:0][AW-1:0] slot_addr,
  output logic [DEPTH-1:0][DW-1:0] slot_data
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic set_v, clr_v, v_d;
    logic v_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;

    always_comb begin
      set_v = push && (wr_ptr == PW'(g));
      clr_v = pop  && (rd_ptr == PW'(g));
      v_d   = v_q;
      if (clr_v) v_d = 1'b0;
      if (set_v) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else if (set_v || clr_v) v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (set_v) begin
        a_q <= st_addr;
        d_q <= st_data;
      end
    end

    assign slot_vld[g]  = v_q;
    assign slot_addr[g] = a_q;
    assign slot_data[g] = d_q;
  end

  AST_POP_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> slot_vld[rd_ptr]) else $error("pop of empty slot"); // R5
  AST_PUSH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!slot_vld[wr_ptr] || (pop && rd_ptr == wr_ptr))) else $error("slot overwrite"); // R3
endmodule

// File: rtl/wsb_lookup.sv
module wsb_lookup #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic [DEPTH-1:0]         slot_vld,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0][DW-1:0] slot_data,
  input  logic [PW-1:0]            rd_ptr,
  input  logic                     rd_check,
  input  logic [AW-1:0]            rd_addr,
  output logic                     rd_hit,
  output logic [DW-1:0]            rd_data
);
  import wsb_pkg::*;

  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = slot_vld[g] && (slot_addr[g] == rd_addr);
  end

  // Walk from oldest to youngest; later matches override earlier ones.
  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = slot_at(int'(rd_ptr), k, DEPTH);
      if (rd_check && match[s]) begin
        rd_hit  = 1'b1;
        rd_data = slot_data[s];
      end
    end
  end
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
  parameter int DEPTH = wsb_pkg::DEF_DEPTH,
  parameter int AW    = wsb_pkg::DEF_AW,
  parameter int DW    = wsb_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ack,
  input  logic          rd_check,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic                     push, pop;
  logic [PW-1:0]            wr_ptr, rd_ptr;
  logic [CW-1:0]            count;
  logic [DEPTH-1:0]         slot_vld;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;

  wsb_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .mem_ack(mem_ack),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .full(full), .empty(empty), .st_stall(st_stall)
  );

  wsb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .st_addr(st_addr), .st_data(st_data),
    .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data)
  );

  wsb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_look (
    .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data),
    .rd_ptr(rd_ptr), .rd_check(rd_check), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_data(rd_data)
  );

  assign mem_req  = !empty;
  assign mem_addr = slot_addr[rd_ptr];
  assign mem_data = slot_data[rd_ptr];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data))
    else $error("req dropped"); // R4
  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_check) else $error("ungated hit"); // R7
  AST_NO_STALL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !st_stall) else $error("stall with room"); // R1
  AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld) == int'(count)) else $error("valid mismatch"); // R8
endmodule

// File: tb/wt_store_buffer_tb.sv
`timescale 1ns/1ps
module wt_store_buffer_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int DW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, mem_ack, rd_check;
  logic [AW-1:0] st_addr, rd_addr;
  logic [DW-1:0] st_data;
  logic          st_stall, mem_req, rd_hit, empty, full;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [AW-1:0] q_a[$];
  logic [DW-1:0] q_d[$];

  always #2.5 clk = ~clk;

  wt_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_stall(st_stall), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .rd_check(rd_check), .rd_addr(rd_addr), .rd_hit(rd_hit),
    .rd_data(rd_data), .empty(empty), .full(full)
  );
  logic [DW-1:0] rd_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare against model, then advance model.
  task automatic step(input string tag, input bit wv, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input bit ack, input bit rc,
                      input logic [AW-1:0] ra);
    bit e_stall, e_hit, e_pop, e_push;
    logic [DW-1:0] e_rd;
    int sz;
    @(negedge clk);
    st_valid = wv; st_addr = wa; st_data = wd;
    mem_ack = ack; rd_check = rc; rd_addr = ra;
    #1;
    sz = q_a.size();
    e_pop   = (sz > 0) && ack;
    e_push  = wv && ((sz < DEPTH) || e_pop);
    e_stall = wv && !e_push;
    e_hit = 0; e_rd = '0;
    for (int i = 0; i < sz; i++)
      if (rc && q_a[i] == ra) begin e_hit = 1; e_rd = q_d[i]; end
    chk(empty == (sz == 0), "R8", "empty", empty, sz == 0);
    chk(full == (sz == DEPTH), "R8", "full", full, sz == DEPTH);
    chk(st_stall == e_stall, (sz == DEPTH) ? "R2" : "R1", "st_stall", st_stall, e_stall);
    chk(mem_req == (sz > 0), "R4", "mem_req", mem_req, sz > 0);
    if (sz > 0) begin
      chk(mem_addr == q_a[0], tag, "mem_addr", mem_addr, q_a[0]);
      chk(mem_data == q_d[0], tag, "mem_data", mem_data, q_d[0]);
    end
    chk(rd_hit == e_hit, e_hit ? "R6" : "R7", "rd_hit", rd_hit, e_hit);
    if (e_hit) chk(rd_data == e_rd, "R6", "rd_data", rd_data, e_rd);
    if (e_pop) begin void'(q_a.pop_front()); void'(q_d.pop_front()); end
    if (e_push) begin q_a.push_back(wa); q_d.push_back(wd); end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0;
    mem_ack = 0; rd_check = 0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(empty == 1 && full == 0 && mem_req == 0 && rd_hit == 0, "R9",
        "reset flags", {empty, full, mem_req, rd_hit}, 4'b1000);
    @(negedge clk); rst_n = 1;
    // R10: stray acknowledges on empty buffer
    step("R10", 0, 0, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 1, 1, 8'h10);
    // R1: fill without stall, repeated addresses
    step("R1", 1, 8'h10, 16'hA000, 0, 0, 0);
    step("R1", 1, 8'h20, 16'hA001, 0, 1, 8'h10);
    step("R1", 1, 8'h10, 16'hA002, 0, 1, 8'h10);
    step("R1", 1, 8'h30, 16'hA003, 0, 1, 8'h10);
    // R2: full, no ack
    step("R2", 1, 8'h40, 16'hB000, 0, 1, 8'h40);
    step("R2", 1, 8'h40, 16'hB000, 0, 1, 8'h30);
    // R3: full with ack and store in the same cycle
    step("R3", 1, 8'h40, 16'hB000, 1, 1, 8'h10);
    step("R3", 1, 8'h10, 16'hB001, 1, 1, 8'h10);
    step("R3", 0, 0, 0, 0, 1, 8'h10);
    // R5: drain in order with gaps
    for (int i = 0; i < 8; i++) step("R5", 0, 0, 0, i[0], 1, 8'h40);
    step("R10", 0, 0, 0, 1, 1, 8'h40);
    // R6: wrapped pointers, several matches
    for (int i = 0; i < 12; i++)
      step("R6", 1, (i % 3 == 0) ? 8'h55 : 8'h66, 16'(16'hC000 + i),
           (i % 4 == 3), 1, 8'h55);
    for (int i = 0; i < 6; i++) step("R5", 0, 0, 0, 1, 1, 8'h66);
    // R4: random mix with slow memory
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pool;
      pool = AW'($urandom_range(0, 5));
      step("R4", ($urandom_range(0, 99) < 55), AW'($urandom_range(0, 5)),
           DW'($urandom), ($urandom_range(0, 99) < 40), $urandom_range(0, 1), pool);
    end
    for (int i = 0; i < DEPTH + 2; i++) step("R5", 0, 0, 0, 1, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule